// File: doc/BRIEF.md
# Countdown Timer Peripheral

A single down-counting timer sitting behind a small word-wide register port. Software programs a start value, selects one of two counting modes and enables the timer. While enabled, the counter drops by one every clock. In periodic mode it restarts from the programmed start value after it passes zero. In free-running mode it rolls over to all ones.

Each pass through zero latches a sticky interrupt flag. A per-timer mask gates that flag onto the interrupt pin and onto two masked status words. A third status word always shows the unmasked flag. Software acknowledges the interrupt by reading either of two acknowledge words; the read itself clears the flag. A constant identification word lets software confirm which block revision it is talking to.

The port is a single-cycle strobe. `bus_sel` together with `bus_wr` marks a write, committed at the clock edge. `bus_sel` with `bus_wr` low marks a read: `bus_rdata` shows the addressed word combinationally during that cycle, and any read side effect takes place at the closing edge.

Top module: `cdt_periph`

## Requirements
- R1: After reset the start value, counter, control word and interrupt flag are all 0, `irq_o` is 0, and the identification word at byte offset 0xAC reads 0x3230352A.
- R2: Registers by byte offset: start value 0x00 (read/write), live count 0x04 (read-only), control 0x08 (read/write), with bit 0 = run, bit 1 = mode (0 free-running, 1 periodic) and bit 2 = mask (1 blocks the interrupt). Control bits 31:3 always read 0.
- R3: The first clock edge that sees the run bit at 1 after it was 0 loads the start value into the counter. Every later edge with run at 1 lowers a nonzero count by one.
- R4: At a count of 0 with the timer running, the next edge loads the start value in periodic mode, or 0xFFFFFFFF in free-running mode.
- R5: With run at 0, the counter holds its value and the interrupt flag is never set.
- R6: The interrupt flag sets on the edge at which a running counter leaves 0. It stays set until acknowledged. Reads of the status words at 0x10, 0xA0 and 0xA8 do not clear it.
- R7: A read of 0x0C or 0xA4 returns 0 and clears the flag at the closing edge. If the counter leaves 0 on that same edge, the flag stays set.
- R8: The words at 0x10 and 0xA0, and the pin `irq_o`, show the flag ANDed with the inverted mask bit. The word at 0xA8 shows the unmasked flag.
- R9: Reads of any unmapped offset return 0. Writes to read-only or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, 0 when not mapped |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bound checker watches the following on every cycle:
- the counter holding while stopped, stepping down by exactly one while running, and reloading or wrapping on leaving zero;
- the flag setting after a zero event, staying set without an acknowledge, and clearing after an acknowledge that meets no zero event;
- the pin following the flag and mask.

Only the bench's scenarios can show the rest:
- the register map as software sees it, including read-back of control bits and values of unmapped offsets;
- that writes to read-only words are ignored;
- the exact cycle at which the load-on-enable happens;
- the case where a zero event and an acknowledge read meet on the same edge.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int unsigned BUS_AW = 8;
    localparam logic [31:0] ID_WORD = 32'h3230_352A;

    // byte offsets
    localparam logic [BUS_AW-1:0] OFS_START  = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_COUNT  = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_CTRL   = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_ACK    = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_MSTAT  = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_GMSTAT = 8'hA0;
    localparam logic [BUS_AW-1:0] OFS_GACK   = 8'hA4;
    localparam logic [BUS_AW-1:0] OFS_GRAW   = 8'hA8;
    localparam logic [BUS_AW-1:0] OFS_ID     = 8'hAC;

    typedef enum logic {
        MODE_FREE     = 1'b0,
        MODE_PERIODIC = 1'b1
    } cnt_mode_e;

    // packed so that run lands in bit 0, mode in bit 1, mask in bit 2
    typedef struct packed {
        logic      mask;
        cnt_mode_e mode;
        logic      run;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    function automatic logic is_ack(input logic [BUS_AW-1:0] a);
        return (a == OFS_ACK) || (a == OFS_GACK);
    endfunction

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter logic [DW-1:0] ID_VAL = DW'(ID_WORD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     cnt,
    input  logic              flag,
    output logic [DW-1:0]     bus_rdata,
    output logic [DW-1:0]     start_q,
    output ctrl_t             ctrl_q,
    output logic              ack_rd
);
    logic wr_en;
    logic masked;

    assign wr_en  = bus_sel && bus_wr;
    assign ack_rd = bus_sel && !bus_wr && is_ack(bus_addr);
    assign masked = flag && !ctrl_q.mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            if (bus_addr == OFS_START) start_q <= bus_wdata;
            if (bus_addr == OFS_CTRL)  ctrl_q  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_START:              bus_rdata = start_q;
            OFS_COUNT:              bus_rdata = cnt;
            OFS_CTRL:               bus_rdata[CTRL_W-1:0] = ctrl_q;
            OFS_MSTAT, OFS_GMSTAT:  bus_rdata[0] = masked;
            OFS_GRAW:               bus_rdata[0] = flag;
            OFS_ID:                 bus_rdata = ID_VAL;
            default:                bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  cnt_mode_e     mode,
    input  logic [DW-1:0] start,
    output logic [DW-1:0] cnt,
    output logic          was_run,
    output logic          zero_evt
);
    logic at_zero;

    assign at_zero  = (cnt == '0);
    assign zero_evt = run && was_run && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            was_run <= 1'b0;
        end else begin
            was_run <= run;
            if (run && !was_run) begin
                cnt <= start;
            end else if (run) begin
                if (at_zero)
                    cnt <= (mode == MODE_PERIODIC) ? start : '1;
                else
                    cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
    input  logic clk,
    input  logic rst,
    input  logic zero_evt,
    input  logic ack_rd,
    input  logic mask,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (zero_evt)
            flag <= 1'b1;   // set beats a same-edge acknowledge
        else if (ack_rd)
            flag <= 1'b0;
    end

    assign irq = flag && !mask;
endmodule

// File: rtl/cdt_periph.sv
module cdt_periph
    import cdt_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_o
);
    ctrl_t         ctrl_w;
    logic [DW-1:0] start_w;
    logic [DW-1:0] cnt_w;
    logic          was_run_w;
    logic          zero_w;
    logic          ack_w;
    logic          flag_w;
    logic          run_w;
    logic          mode_w;
    logic          mask_w;

    assign run_w  = ctrl_w.run;
    assign mode_w = ctrl_w.mode;
    assign mask_w = ctrl_w.mask;

    cdt_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt_w),
        .flag      (flag_w),
        .bus_rdata (bus_rdata),
        .start_q   (start_w),
        .ctrl_q    (ctrl_w),
        .ack_rd    (ack_w)
    );

    cdt_counter #(.DW(DW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_w.run),
        .mode     (ctrl_w.mode),
        .start    (start_w),
        .cnt      (cnt_w),
        .was_run  (was_run_w),
        .zero_evt (zero_w)
    );

    cdt_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .zero_evt (zero_w),
        .ack_rd   (ack_w),
        .mask     (ctrl_w.mask),
        .flag     (flag_w),
        .irq      (irq_o)
    );
endmodule

// File: rtl/cdt_checks.sv
module cdt_checks #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          run,
    input logic          was_run,
    input logic          mode,
    input logic          mask,
    input logic [DW-1:0] start,
    input logic [DW-1:0] cnt,
    input logic          zero_evt,
    input logic          ack_rd,
    input logic          flag,
    input logic          irq
);
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (run && was_run && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        (run && was_run && cnt == '0 && mode) |=> (cnt == $past(start)));

    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (run && was_run && cnt == '0 && !mode) |=> (cnt == '1));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt));

    a_r5_no_evt: assert property (@(posedge clk) disable iff (rst)
        (!run && !flag) |=> !flag);

    a_r6_set: assert property (@(posedge clk) disable iff (rst)
        zero_evt |=> flag);

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !ack_rd) |=> flag);

    a_r7_ack_clear: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !zero_evt) |=> !flag);

    a_r8_pin: assert property (@(posedge clk) disable iff (rst)
        irq == (flag && !mask));
endmodule

bind cdt_periph cdt_checks #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run_w),
    .was_run  (was_run_w),
    .mode     (mode_w),
    .mask     (mask_w),
    .start    (start_w),
    .cnt      (cnt_w),
    .zero_evt (zero_w),
    .ack_rd   (ack_w),
    .flag     (flag_w),
    .irq      (irq_o)
);

// File: tb/cdt_periph_tb.sv
module cdt_periph_tb;
    localparam logic [31:0] VER = 32'h3230_352A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    typedef struct {
        logic [7:0]  a;
        logic [31:0] v;
        string       tag;
    } item_t;

    item_t exp_q[$];
    item_t it;

    always #10 clk = ~clk;

    cdt_periph u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // monitor: compare each read against the oldest expected item
    always @(negedge clk) begin
        if (bus_sel && !bus_wr && exp_q.size() > 0) begin
            it = exp_q.pop_front();
            checks++;
            if (bus_rdata !== it.v) begin
                errors++;
                $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                         it.tag, it.a, bus_rdata, it.v);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back('{a, e, tag});
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL %s irq_o actual=%0b expected=%0b", tag, irq_o, e);
        end
    endtask

    initial begin
        logic [31:0] held;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(8'h00, 32'h0, "R1 start");
        rd(8'h04, 32'h0, "R1 count");
        rd(8'h08, 32'h0, "R1 ctrl");
        rd(8'hA8, 32'h0, "R1 raw");
        rd(8'hAC, VER,   "R1 id");
        chk_irq(1'b0, "R1 irq");

        // R3 load on enable, then step down
        wr(8'h00, 32'd100);
        rd(8'h00, 32'd100, "R2 start readback");
        wr(8'h08, 32'h3);
        rd(8'h04, 32'd0,   "R3 before load");
        rd(8'h04, 32'd100, "R3 loaded");
        rd(8'h04, 32'd99,  "R3 step");
        idle(10);
        rd(8'h04, 32'd88,  "R3 steps");

        // R4 periodic reload, R6/R7/R8 flag handling
        wr(8'h08, 32'h0);
        wr(8'h00, 32'd3);
        wr(8'h08, 32'h3);
        idle(1);
        rd(8'h04, 32'd3, "R4 count3");
        rd(8'h04, 32'd2, "R4 count2");
        rd(8'h04, 32'd1, "R4 count1");
        rd(8'h04, 32'd0, "R4 count0");
        rd(8'hA8, 32'd1, "R6 raw set");
        rd(8'h10, 32'd1, "R8 stat 10");
        rd(8'hA0, 32'd1, "R8 stat A0");
        chk_irq(1'b1, "R8 irq on");
        rd(8'h0C, 32'd0, "R7 ack returns 0");
        rd(8'hA8, 32'd1, "R7 set wins over ack");
        rd(8'hA4, 32'd0, "R7 global ack returns 0");
        rd(8'hA8, 32'd0, "R7 cleared");
        chk_irq(1'b0, "R7 irq off");
        idle(1);
        rd(8'hA8, 32'd1, "R4 reload period");
        wr(8'h08, 32'h7);
        rd(8'h10, 32'd0, "R8 masked stat");
        chk_irq(1'b0, "R8 masked irq");
        rd(8'hA8, 32'd1, "R6 raw sticky");

        // R5 stopped timer holds
        wr(8'h08, 32'h0);
        peek(8'h04, held);
        rd(8'h0C, 32'd0, "R7 ack");
        idle(20);
        rd(8'hA8, 32'd0, "R5 no event");
        rd(8'h04, held,  "R5 hold");

        // R2/R9 map and ignored writes
        wr(8'h08, 32'hFFFF_FFF6);
        rd(8'h08, 32'h6, "R2 ctrl upper zero");
        wr(8'h04, 32'h1234);
        rd(8'h04, held, "R9 count read-only");
        wr(8'hAC, 32'h0);
        rd(8'hAC, VER, "R9 id read-only");
        wr(8'h20, 32'hDEAD);
        rd(8'h00, 32'd3, "R9 unmapped write");
        rd(8'h14, 32'd0, "R9 unmapped 14");
        rd(8'hB0, 32'd0, "R9 unmapped B0");

        // R4 free-running wrap
        wr(8'h00, 32'd2);
        wr(8'h08, 32'h1);
        idle(1);
        rd(8'h04, 32'd2, "R4 free 2");
        rd(8'h04, 32'd1, "R4 free 1");
        rd(8'h04, 32'd0, "R4 free 0");
        rd(8'h04, 32'hFFFF_FFFF, "R4 wrap");
        rd(8'h04, 32'hFFFF_FFFE, "R4 after wrap");
        rd(8'hA8, 32'd1, "R6 free raw");
        chk_irq(1'b1, "R8 free irq");

        idle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule